// File: doc/BRIEF.md
# Edge-Timestamp Capture Channel with Two-Deep Sample Store

This block is one channel of a timer's input-capture section. It watches an external pin, brings it into the clock domain through a flop synchronizer and detects edges. When a chosen edge arrives, it records the value of the shared timebase counter. The samples are held in a two-entry store: a primary data register and a secondary buffer. Software reads them oldest first. Each read of the primary register moves the buffered sample forward.

The channel keeps three flags:
- An event flag, which means the primary register holds an unread sample.
- A buffer-valid flag, which means the secondary buffer holds one.
- A sticky error flag, which is raised when a sample arrives while both entries are occupied. That sample is dropped.

In the period and pulse-width modes the channel also raises a one-cycle request asking the timebase to zero the shared counter. The timebase, the bus decoding and the interrupt logic sit outside this block.

Top module: `capture_fifo_channel`

## Requirements
- R1: The pin goes through two synchronizer flops before edge detection. A pin change that is present before rising clock edge k is stored at rising edge k+2, and the stored value is `count_i` as held during the cycle before that edge. The event flag is still 0 after edge k+1.
- R2: In normal mode, `edge_sel_i` selects the capture edge: 00 captures rising edges, 01 captures falling edges and 10 captures both. 11 captures nothing.
- R3: `cap_mode_i` selects the mode: 00 is normal, 01 is period, 10 is pulse-width and 11 is inactive. Inactive mode captures nothing and never requests a counter reset.
- R4: A capture while the event flag is 0 writes the count into the primary register and sets the event flag.
- R5: A capture while the event flag is 1 and the buffer-valid flag is 0 writes the count into the secondary buffer and sets the buffer-valid flag. The primary register is unchanged.
- R6: Reading the primary register while the buffer-valid flag is 1 copies the secondary buffer into the primary register, clears the buffer-valid flag and leaves the event flag set. Reading it while the buffer-valid flag is 0 clears the event flag.
- R7: A capture while both flags are 1 sets the error flag, drops the sample and leaves both stored entries unchanged.
- R8: Reading the secondary buffer clears the buffer-valid flag.
- R9: In period mode, a rising edge stores the count and asserts `cnt_zero_req_o` for one cycle. A falling edge does neither.
- R10: In pulse-width mode, a rising edge asserts `cnt_zero_req_o` for one cycle without storing. A falling edge stores the count without a reset request.
- R11: When a capture and a primary read fall in the same cycle, the read acts first. With both entries full, the buffered sample moves to the primary register, the new sample fills the secondary buffer and no error is raised.
- R12: While `chan_en_i` is 0, no edge stores a sample or requests a counter reset.
- R13: `err_clr_i` clears the error flag. A new overflow in the same cycle takes priority and keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Raw external capture pin |
| count_i | input | CNT_W | Shared timebase counter value |
| chan_en_i | input | 1 | Channel enable |
| cap_mode_i | input | 2 | Mode: 00 normal, 01 period, 10 pulse-width, 11 inactive |
| edge_sel_i | input | 2 | Edge select in normal mode: 00 rising, 01 falling, 10 both, 11 none |
| rd_primary_i | input | 1 | One-cycle strobe: primary register is being read |
| rd_secondary_i | input | 1 | One-cycle strobe: secondary buffer is being read |
| err_clr_i | input | 1 | One-cycle strobe clearing the error flag |
| primary_o | output | CNT_W | Primary data register (oldest sample) |
| secondary_o | output | CNT_W | Secondary buffer (newer sample) |
| evt_flag_o | output | 1 | Primary register holds an unread sample |
| bv_flag_o | output | 1 | Secondary buffer holds an unread sample |
| err_flag_o | output | 1 | Sticky overflow error flag |
| cnt_zero_req_o | output | 1 | One-cycle request to zero the shared counter |

## Verification
The assertions assume that the read and clear strobes are single-cycle pulses and that the mode, edge-select and enable inputs are quasi-static around edges. They also assume the pin is low when reset is released, so that no false edge comes out of the synchronizer. The stimulus follows these rules:
- Every input is changed on the falling clock edge.
- The pin is held long enough for each transition to pass fully through the synchronizer.
- Configuration changes happen only while the pin is idle.
- Read strobes are raised for exactly one cycle. The one deliberate overlap of a read with a capture is placed in the cycle in which the capture lands.

// File: rtl/capchan_pkg.sv
package capchan_pkg;

  typedef enum logic [1:0] {
    EDG_RISE = 2'b00,
    EDG_FALL = 2'b01,
    EDG_BOTH = 2'b10,
    EDG_NONE = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'b00,
    CM_PERIOD = 2'b01,
    CM_PULSE  = 2'b10,
    CM_OFF    = 2'b11
  } cap_mode_e;

  typedef struct packed {
    logic store;
    logic zero;
  } cap_act_t;

  // Does the detected edge match the selected edge kind?
  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    case (sel)
      EDG_RISE: return rise;
      EDG_FALL: return fall;
      EDG_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

  // Map mode, edge selection and detected edges onto store / counter-zero actions.
  function automatic cap_act_t decode_action(input cap_mode_e mode, input edge_sel_e sel,
                                             input logic rise, input logic fall, input logic en);
    cap_act_t a;
    a = '0;
    if (en) begin
      case (mode)
        CM_NORMAL: a.store = edge_hit(sel, rise, fall);
        CM_PERIOD: begin a.store = rise; a.zero = rise; end
        CM_PULSE:  begin a.store = fall; a.zero = rise; end
        default:   a = '0;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES;

  // Index 0..SYNC_STAGES-1 is the synchronizer, index SYNC_STAGES holds the previous value.
  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], pin_i};
  end

  assign rise_o =  chain_q[LAST-1] & ~chain_q[LAST];
  assign fall_o = ~chain_q[LAST-1] &  chain_q[LAST];
endmodule

// File: rtl/cap_event_decode.sv
module cap_event_decode
  import capchan_pkg::*;
(
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] sel_i,
  output logic       store_o,
  output logic       zero_o
);
  cap_act_t act;

  always_comb begin
    act     = decode_action(cap_mode_e'(mode_i), edge_sel_e'(sel_i), rise_i, fall_i, en_i);
    store_o = act.store;
    zero_o  = act.zero;
  end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rd_pri_i,
  input  logic             rd_sec_i,
  input  logic             err_clr_i,
  output logic [CNT_W-1:0] pri_o,
  output logic [CNT_W-1:0] sec_o,
  output logic             evt_o,
  output logic             bv_o,
  output logic             err_o,
  output logic             drop_o
);
  logic [CNT_W-1:0] pri_q, sec_q, pri_d, sec_d;
  logic             evt_q, bv_q, err_q, evt_d, bv_d, err_d;
  logic             evt_r, bv_r;

  always_comb begin
    pri_d = pri_q;
    sec_d = sec_q;
    evt_r = evt_q;
    bv_r  = bv_q;
    // Reads are applied first.
    if (rd_pri_i) begin
      if (bv_q) begin
        pri_d = sec_q;
        bv_r  = 1'b0;
      end else begin
        evt_r = 1'b0;
      end
    end
    if (rd_sec_i) bv_r = 1'b0;
    // Then the incoming sample fills the first free entry.
    drop_o = store_i & evt_r & bv_r;
    evt_d  = evt_r;
    bv_d   = bv_r;
    if (store_i && !evt_r) begin
      pri_d = count_i;
      evt_d = 1'b1;
    end else if (store_i && !bv_r) begin
      sec_d = count_i;
      bv_d  = 1'b1;
    end
    err_d = drop_o ? 1'b1 : (err_clr_i ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
      evt_q <= 1'b0;
      bv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
      evt_q <= evt_d;
      bv_q  <= bv_d;
      err_q <= err_d;
    end
  end

  assign pri_o = pri_q;
  assign sec_o = sec_q;
  assign evt_o = evt_q;
  assign bv_o  = bv_q;
  assign err_o = err_q;
endmodule

// File: rtl/capture_fifo_channel.sv
module capture_fifo_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             chan_en_i,
  input  logic [1:0]       cap_mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             rd_primary_i,
  input  logic             rd_secondary_i,
  input  logic             err_clr_i,
  output logic [CNT_W-1:0] primary_o,
  output logic [CNT_W-1:0] secondary_o,
  output logic             evt_flag_o,
  output logic             bv_flag_o,
  output logic             err_flag_o,
  output logic             cnt_zero_req_o
);
  // Named internal events, brought out for the checker.
  logic pin_rise, pin_fall;
  logic cap_store_stb;
  logic fifo_drop;

  cap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  cap_event_decode u_dec (
    .rise_i  (pin_rise),
    .fall_i  (pin_fall),
    .en_i    (chan_en_i),
    .mode_i  (cap_mode_i),
    .sel_i   (edge_sel_i),
    .store_o (cap_store_stb),
    .zero_o  (cnt_zero_req_o)
  );

  cap_store #(.CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_i   (cap_store_stb),
    .count_i   (count_i),
    .rd_pri_i  (rd_primary_i),
    .rd_sec_i  (rd_secondary_i),
    .err_clr_i (err_clr_i),
    .pri_o     (primary_o),
    .sec_o     (secondary_o),
    .evt_o     (evt_flag_o),
    .bv_o      (bv_flag_o),
    .err_o     (err_flag_o),
    .drop_o    (fifo_drop)
  );
endmodule

// File: rtl/capture_fifo_channel_chk.sv
module capture_fifo_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic             chan_en_i,
  input logic [1:0]       cap_mode_i,
  input logic [1:0]       edge_sel_i,
  input logic             rd_primary_i,
  input logic             rd_secondary_i,
  input logic             err_clr_i,
  input logic [CNT_W-1:0] primary_o,
  input logic [CNT_W-1:0] secondary_o,
  input logic             evt_flag_o,
  input logic             bv_flag_o,
  input logic             err_flag_o,
  input logic             cnt_zero_req_o,
  input logic             cap_store_stb,
  input logic             fifo_drop
);
  a_r2_reserved_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode_i == 2'b00 && edge_sel_i == 2'b11) |-> !cap_store_stb);

  a_r3_inactive_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode_i == 2'b11) |-> (!cap_store_stb && !cnt_zero_req_o));

  a_r4_fill_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_store_stb && !evt_flag_o && !rd_primary_i) |=> (evt_flag_o && primary_o == $past(count_i)));

  a_r5_fill_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_store_stb && evt_flag_o && !bv_flag_o && !rd_primary_i && !rd_secondary_i)
    |=> (bv_flag_o && secondary_o == $past(count_i) && $stable(primary_o)));

  a_r6_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_primary_i && bv_flag_o && !cap_store_stb)
    |=> (primary_o == $past(secondary_o) && !bv_flag_o && evt_flag_o));

  a_r6_valid_implies_event: assert property (@(posedge clk) disable iff (!rst_n)
    bv_flag_o |-> evt_flag_o);

  a_r7_overflow_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_store_stb && evt_flag_o && bv_flag_o && !rd_primary_i && !rd_secondary_i)
    |=> (err_flag_o && $stable(primary_o) && $stable(secondary_o)));

  a_r8_sec_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_secondary_i && !cap_store_stb) |=> !bv_flag_o);

  a_r9_period_zero_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode_i == 2'b01 && cnt_zero_req_o) |-> cap_store_stb);

  a_r10_pulse_zero_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode_i == 2'b10 && cnt_zero_req_o) |-> !cap_store_stb);

  a_r11_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_store_stb && rd_primary_i && !rd_secondary_i && evt_flag_o && bv_flag_o)
    |=> (primary_o == $past(secondary_o) && secondary_o == $past(count_i) && bv_flag_o && !fifo_drop));

  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_i |-> (!cap_store_stb && !cnt_zero_req_o));

  a_r13_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !fifo_drop) |=> !err_flag_o);
endmodule

bind capture_fifo_channel capture_fifo_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_capture_fifo_channel.sv
`timescale 1ns/1ps
module tb_capture_fifo_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pin = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         en = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [1:0]   esel = 2'b00;
  logic         rd_p = 1'b0, rd_s = 1'b0, eclr = 1'b0;
  logic [W-1:0] pri, sec;
  logic         evt, bv, err, zreq;

  int tests = 0, fails = 0, zcnt = 0;
  bit done = 0;
  logic [W-1:0] sb[$];   // scoreboard: expected stored samples, oldest first

  always #10 clk = ~clk;  // 50 MHz

  capture_fifo_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cap_pin_i(pin), .count_i(cnt), .chan_en_i(en),
    .cap_mode_i(mode), .edge_sel_i(esel), .rd_primary_i(rd_p), .rd_secondary_i(rd_s),
    .err_clr_i(eclr), .primary_o(pri), .secondary_o(sec), .evt_flag_o(evt),
    .bv_flag_o(bv), .err_flag_o(err), .cnt_zero_req_o(zreq));

  // Monitor: counts cycles in which a counter reset is requested.
  always @(negedge clk) if (rst_n && zreq) zcnt++;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: move the pin, let it pass the synchronizer, record the expected sample.
  task automatic drive_pin(logic v, logic [W-1:0] c, bit stores);
    @(negedge clk);
    cnt = c;
    pin = v;
    repeat (4) @(negedge clk);
    if (stores && sb.size() < 2) sb.push_back(c);
  endtask

  // Read the primary register and compare it against the scoreboard head.
  task automatic read_pri(string req);
    @(negedge clk);
    if (sb.size() > 0) chk(req, "primary vs scoreboard", pri, sb[0]);
    rd_p = 1'b1;
    @(negedge clk);
    rd_p = 1'b0;
    if (sb.size() > 0) void'(sb.pop_front());
  endtask

  task automatic read_sec(string req);
    @(negedge clk);
    if (sb.size() > 1) chk(req, "secondary vs scoreboard", sec, sb[1]);
    rd_s = 1'b1;
    @(negedge clk);
    rd_s = 1'b0;
    if (sb.size() > 1) sb.delete(1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int z0;
    repeat (3) @(negedge clk);
    chk("reset", "evt", evt, 0);
    chk("reset", "bv", bv, 0);
    chk("reset", "err", err, 0);
    chk("reset", "primary", pri, 0);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (2) @(negedge clk);

    // R1 and R4: synchronizer latency and first sample into the primary register.
    @(negedge clk); cnt = 16'd100; pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", "evt after two edges", evt, 0);
    @(negedge clk);
    chk("R1", "evt after three edges", evt, 1);
    chk("R4", "primary", pri, 16'd100);
    sb.push_back(16'd100);
    // R2: falling edge is ignored under rising-edge selection.
    drive_pin(1'b0, 16'd101, 0);
    chk("R2", "bv after ignored fall", bv, 0);
    chk("R2", "primary unchanged", pri, 16'd100);
    // R5: second sample goes to the secondary buffer.
    drive_pin(1'b1, 16'd200, 1);
    chk("R5", "bv", bv, 1);
    chk("R5", "secondary", sec, 16'd200);
    chk("R5", "primary kept", pri, 16'd100);
    drive_pin(1'b0, 16'd201, 0);
    // R7: overflow raises the error flag and drops the sample.
    drive_pin(1'b1, 16'd300, 1);
    chk("R7", "err", err, 1);
    chk("R7", "primary kept", pri, 16'd100);
    chk("R7", "secondary kept", sec, 16'd200);
    // R13: clearing the error flag.
    @(negedge clk); eclr = 1'b1; @(negedge clk); eclr = 1'b0;
    chk("R13", "err cleared", err, 0);
    // R6: reads advance the store.
    read_pri("R6");
    chk("R6", "bv after advance", bv, 0);
    chk("R6", "evt after advance", evt, 1);
    chk("R6", "primary advanced", pri, 16'd200);
    read_pri("R6");
    chk("R6", "evt after last read", evt, 0);
    drive_pin(1'b0, 16'd301, 0);

    // R2: falling-edge selection.
    esel = 2'b01;
    drive_pin(1'b1, 16'd350, 0);
    chk("R2", "rise ignored under falling select", evt, 0);
    drive_pin(1'b0, 16'd400, 1);
    chk("R2", "falling captured", pri, 16'd400);
    read_pri("R2");
    // R2 and R8: both edges, then discard the secondary.
    esel = 2'b10;
    drive_pin(1'b1, 16'd500, 1);
    drive_pin(1'b0, 16'd600, 1);
    chk("R2", "both edges bv", bv, 1);
    read_sec("R8");
    chk("R8", "bv after secondary read", bv, 0);
    chk("R8", "evt kept", evt, 1);
    read_pri("R8");
    // R2: reserved edge code captures nothing.
    esel = 2'b11;
    drive_pin(1'b1, 16'd650, 0);
    drive_pin(1'b0, 16'd660, 0);
    chk("R2", "reserved select evt", evt, 0);

    // R11: capture lands in the same cycle as a primary read while full.
    esel = 2'b10;
    drive_pin(1'b1, 16'd700, 1);
    drive_pin(1'b0, 16'd800, 1);
    @(negedge clk); cnt = 16'd900; pin = 1'b1;
    @(negedge clk); @(negedge clk); rd_p = 1'b1;
    @(negedge clk); rd_p = 1'b0;
    void'(sb.pop_front()); sb.push_back(16'd900);
    chk("R11", "primary", pri, sb[0]);
    chk("R11", "secondary", sec, sb[1]);
    chk("R11", "bv", bv, 1);
    chk("R11", "err", err, 0);
    @(negedge clk); pin = 1'b0;
    repeat (4) @(negedge clk);
    read_sec("R11");
    read_pri("R11");
    chk("R11", "store empty", evt, 0);

    // R9: period mode.
    mode = 2'b01; esel = 2'b00;
    z0 = zcnt;
    drive_pin(1'b1, 16'd1000, 1);
    chk("R9", "rise stores", pri, 16'd1000);
    chk("R9", "one zero request", zcnt - z0, 1);
    drive_pin(1'b0, 16'd1001, 0);
    chk("R9", "fall no request", zcnt - z0, 1);
    chk("R9", "fall no store", bv, 0);
    read_pri("R9");

    // R10: pulse-width mode.
    mode = 2'b10;
    z0 = zcnt;
    drive_pin(1'b1, 16'd1100, 0);
    chk("R10", "rise requests zero", zcnt - z0, 1);
    chk("R10", "rise no store", evt, 0);
    drive_pin(1'b0, 16'd1200, 1);
    chk("R10", "fall stores", pri, 16'd1200);
    chk("R10", "fall no request", zcnt - z0, 1);
    read_pri("R10");

    // R3: inactive mode.
    mode = 2'b11; esel = 2'b10;
    z0 = zcnt;
    drive_pin(1'b1, 16'd1300, 0);
    drive_pin(1'b0, 16'd1310, 0);
    chk("R3", "inactive evt", evt, 0);
    chk("R3", "inactive zero requests", zcnt - z0, 0);

    // R12: channel disabled, period mode would otherwise act.
    mode = 2'b01; en = 1'b0;
    z0 = zcnt;
    drive_pin(1'b1, 16'd1400, 0);
    drive_pin(1'b0, 16'd1410, 0);
    chk("R12", "disabled evt", evt, 0);
    chk("R12", "disabled zero requests", zcnt - z0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule